// File: doc/BRIEF.md
# Flag Offset Programming Unit

This block holds the two threshold offsets that a deep FIFO's almost-empty and almost-full flag logic compares against: an empty-side offset and a full-side offset, each `log2(DEPTH)` bits wide. It also decodes the shared control pins. With the load-select pin high, the write-side and read-side enables act on the offset registers. With it low, they pass through as FIFO memory write and read strobes.

During master reset, the load-select pin acts as a strap and fixes two things. The first is the programming method: bit-serial shifting, or parallel words from the data bus. The second is the default value of both offsets: 1023 for serial and 127 for parallel. Partial reset keeps the offsets and the method. It only returns both access pointers to the empty-side register. In serial mode the two registers form one shift chain. In parallel mode, successive writes go to the empty and full registers in turn, and the read port returns them in the same turn whatever method was chosen. Both resets are synchronous and active low, and each clock domain samples them itself.

Top module: `ofs_prog_unit`

## Requirements
- R1: On a write-clock edge with `mst_rst_n` low, `serial_mode` takes the value of `ofs_sel`. Both offsets become 1023 when `ofs_sel` is 1 and 127 when it is 0.
- R2: A partial reset (`prt_rst_n` low, `mst_rst_n` high) leaves `empty_ofs`, `full_ofs` and `serial_mode` unchanged. It returns both the write and read alternation to the empty-side register, and it clears `rd_data` and `ofs_rd_vld`.
- R3: In parallel mode (`serial_mode`=0), each write-clock edge with `ofs_sel`=1 and `wr_en`=1 loads `wr_data[OW-1:0]`. The first such write after a reset goes to the empty offset, the next to the full offset, and so on alternately.
- R4: In serial mode, each write-clock edge with `ofs_sel`=1 and `ser_en`=1 shifts `ser_din` into bit 2·OW-1 of the chain {full_ofs, empty_ofs}. The chain moves one place toward bit 0, which is the empty-offset LSB, so after 2·OW shifts the first bit sent sits in the empty-offset LSB.
- R5: A read-clock edge with `ofs_sel`=1 and `rd_en`=1 puts an offset, zero-extended, on `rd_data` and sets `ofs_rd_vld` for exactly one cycle. The first read after a reset returns the empty offset, the next the full offset, and so on alternately.
- R6: Offset read-back works the same in serial mode and in parallel mode.
- R7: `mem_wr` is 1 exactly when both resets are high, `ofs_sel`=0 and `wr_en`=1. `mem_rd` is 1 exactly when both resets are high, `ofs_sel`=0 and `rd_en`=1.
- R8: An access that does not match the strapped method is ignored: a parallel write in serial mode, or a serial shift in parallel mode. The offsets stay unchanged and the write alternation does not advance.
- R9: The offsets can be rewritten any number of times after master reset, and the latest write or shift takes effect.
- R10: `rd_data` holds its value on read-clock edges that perform no offset read and no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mst_rst_n | input | 1 | Master reset, synchronous, active low; samples the strap |
| prt_rst_n | input | 1 | Partial reset, synchronous, active low |
| ofs_sel | input | 1 | Offset register select; strap during master reset |
| wr_en | input | 1 | Write enable (memory or offset) |
| rd_en | input | 1 | Read enable (memory or offset) |
| ser_en | input | 1 | Serial shift enable |
| ser_din | input | 1 | Serial offset bit |
| wr_data | input | DW | Write data bus; low OW bits carry a parallel offset |
| mem_wr | output | 1 | FIFO memory write strobe |
| mem_rd | output | 1 | FIFO memory read strobe |
| rd_data | output | DW | Offset read-back data |
| ofs_rd_vld | output | 1 | `rd_data` holds a freshly read offset |
| empty_ofs | output | OW | Empty-side offset to flag logic |
| full_ofs | output | OW | Full-side offset to flag logic |
| serial_mode | output | 1 | 1 = serial programming strapped |

## Verification
A write pointer stuck on one register shows up at the offset ports on the second parallel write after a reset, because the wrong register changes. A read pointer that fails to toggle shows up on `rd_data` one read-clock cycle after the second read. An error in shift direction or entry point shows as a wrong `empty_ofs`/`full_ofs` value after the first shifted bit. A wrong strap capture shows on `serial_mode` and on both offsets one edge after master reset. The bench compares every port after every edge, so each of these faults is caught within the cycle it first appears.

// File: rtl/ofs_pkg.sv
// Package: shared types for the flag offset programming unit.
// Assumes nothing beyond standard SystemVerilog.
package ofs_pkg;

    // Which offset register a parallel access addresses.
    typedef enum logic {
        SEL_EMPTY = 1'b0,
        SEL_FULL  = 1'b1
    } ofs_sel_e;

    // Alternation step between the two registers.
    function automatic ofs_sel_e flip_sel(input ofs_sel_e cur);
        return (cur == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
    endfunction

endpackage

// File: rtl/ofs_wr_side.sv
// Module: write-clock side of the offset unit. Captures the method strap at
// master reset, holds both offsets, applies parallel writes (alternating) or
// serial shifts (one chain, entering at the full-offset MSB).
// Assumes: synchronous active-low resets already in the write-clock domain.
module ofs_wr_side
    import ofs_pkg::*;
#(
    parameter int OW      = 13,
    parameter int DEF_SER = 1023,
    parameter int DEF_PAR = 127
) (
    input  logic          clk,
    input  logic          mst_rst_n,
    input  logic          prt_rst_n,
    input  logic          ofs_sel,
    input  logic          wr_en,
    input  logic          ser_en,
    input  logic          ser_din,
    input  logic [OW-1:0] wr_val,
    output logic [OW-1:0] empty_ofs,
    output logic [OW-1:0] full_ofs,
    output logic          serial_mode
);

    localparam int CW = 2 * OW;
    localparam logic [OW-1:0] DEF_S = DEF_SER[OW-1:0];
    localparam logic [OW-1:0] DEF_P = DEF_PAR[OW-1:0];

    ofs_sel_e      wsel;
    logic          par_wr;
    logic          ser_sh;
    logic [CW-1:0] chain_nxt;

    // Decode accesses that match the strapped method; others are dropped.
    always_comb begin
        par_wr    = prt_rst_n && ofs_sel && wr_en  && !serial_mode;
        ser_sh    = prt_rst_n && ofs_sel && ser_en &&  serial_mode;
        chain_nxt = {ser_din, full_ofs, empty_ofs[OW-1:1]};
    end

    // Strap capture of the programming method.
    always_ff @(posedge clk) begin
        if (!mst_rst_n) serial_mode <= ofs_sel;
    end

    // Write alternation pointer.
    always_ff @(posedge clk) begin
        if (!mst_rst_n || !prt_rst_n) wsel <= SEL_EMPTY;
        else if (par_wr)              wsel <= flip_sel(wsel);
    end

    // Offset registers: defaults, parallel loads, serial shifts.
    always_ff @(posedge clk) begin
        if (!mst_rst_n) begin
            empty_ofs <= ofs_sel ? DEF_S : DEF_P;
            full_ofs  <= ofs_sel ? DEF_S : DEF_P;
        end else if (par_wr) begin
            if (wsel == SEL_EMPTY) empty_ofs <= wr_val;
            else                   full_ofs  <= wr_val;
        end else if (ser_sh) begin
            {full_ofs, empty_ofs} <= chain_nxt;
        end
    end

endmodule

// File: rtl/ofs_rd_side.sv
// Module: read-clock side of the offset unit. Returns the offsets on the
// data output, alternating empty/full, and flags each returned word.
// Assumes: offsets are quasi-static relative to rd_clk when read back.
module ofs_rd_side
    import ofs_pkg::*;
#(
    parameter int OW = 13,
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          mst_rst_n,
    input  logic          prt_rst_n,
    input  logic          ofs_sel,
    input  logic          rd_en,
    input  logic [OW-1:0] empty_ofs,
    input  logic [OW-1:0] full_ofs,
    output logic [DW-1:0] rd_data,
    output logic          rd_vld
);

    ofs_sel_e rsel;
    logic     do_rd;

    // Offset read request.
    assign do_rd = ofs_sel && rd_en;

    // Read alternation pointer.
    always_ff @(posedge clk) begin
        if (!mst_rst_n || !prt_rst_n) rsel <= SEL_EMPTY;
        else if (do_rd)               rsel <= flip_sel(rsel);
    end

    // Output register and its valid strobe.
    always_ff @(posedge clk) begin
        if (!mst_rst_n || !prt_rst_n) begin
            rd_data <= '0;
            rd_vld  <= 1'b0;
        end else begin
            rd_vld <= do_rd;
            if (do_rd)
                rd_data <= DW'((rsel == SEL_EMPTY) ? empty_ofs : full_ofs);
        end
    end

endmodule

// File: rtl/ofs_prog_unit.sv
// Module: top of the flag offset programming unit. Routes the shared enables
// either to the offset registers (ofs_sel high) or out as memory strobes.
// Assumes: DW >= OW; both resets synchronous active low in each domain.
module ofs_prog_unit #(
    parameter int DEPTH   = 8192,
    parameter int DW      = 18,
    parameter int DEF_SER = 1023,
    parameter int DEF_PAR = 127
) (
    input  logic                     wr_clk,
    input  logic                     rd_clk,
    input  logic                     mst_rst_n,
    input  logic                     prt_rst_n,
    input  logic                     ofs_sel,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic                     ser_en,
    input  logic                     ser_din,
    input  logic [DW-1:0]            wr_data,
    output logic                     mem_wr,
    output logic                     mem_rd,
    output logic [DW-1:0]            rd_data,
    output logic                     ofs_rd_vld,
    output logic [$clog2(DEPTH)-1:0] empty_ofs,
    output logic [$clog2(DEPTH)-1:0] full_ofs,
    output logic                     serial_mode
);

    localparam int OW = $clog2(DEPTH);

    logic rst_idle;

    // Memory strobes pass only outside reset and with offsets deselected.
    always_comb begin
        rst_idle = mst_rst_n && prt_rst_n;
        mem_wr   = rst_idle && !ofs_sel && wr_en;
        mem_rd   = rst_idle && !ofs_sel && rd_en;
    end

    ofs_wr_side #(.OW(OW), .DEF_SER(DEF_SER), .DEF_PAR(DEF_PAR)) wr_i (
        .clk        (wr_clk),
        .mst_rst_n  (mst_rst_n),
        .prt_rst_n  (prt_rst_n),
        .ofs_sel    (ofs_sel),
        .wr_en      (wr_en),
        .ser_en     (ser_en),
        .ser_din    (ser_din),
        .wr_val     (wr_data[OW-1:0]),
        .empty_ofs  (empty_ofs),
        .full_ofs   (full_ofs),
        .serial_mode(serial_mode)
    );

    ofs_rd_side #(.OW(OW), .DW(DW)) rd_i (
        .clk       (rd_clk),
        .mst_rst_n (mst_rst_n),
        .prt_rst_n (prt_rst_n),
        .ofs_sel   (ofs_sel),
        .rd_en     (rd_en),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs),
        .rd_data   (rd_data),
        .rd_vld    (ofs_rd_vld)
    );

endmodule

// File: rtl/ofs_prog_unit_chk.sv
// Module: property checker for ofs_prog_unit, attached by bind below.
// Assumes: started flags keep $past away from pre-clock values.
module ofs_prog_unit_chk #(
    parameter int OW      = 13,
    parameter int DW      = 18,
    parameter int DEF_SER = 1023,
    parameter int DEF_PAR = 127
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          mst_rst_n,
    input logic          prt_rst_n,
    input logic          ofs_sel,
    input logic          wr_en,
    input logic          rd_en,
    input logic          ser_en,
    input logic          mem_wr,
    input logic          mem_rd,
    input logic [DW-1:0] rd_data,
    input logic          ofs_rd_vld,
    input logic [OW-1:0] empty_ofs,
    input logic [OW-1:0] full_ofs,
    input logic          serial_mode
);

    logic w_started = 1'b0;
    logic r_started = 1'b0;

    // Mark the first edge seen in each domain.
    always_ff @(posedge wr_clk) w_started <= 1'b1;
    always_ff @(posedge rd_clk) r_started <= 1'b1;

    p_strap_defaults_r1: assert property (@(posedge wr_clk)
        (w_started && $past(!mst_rst_n)) |->
            (serial_mode == $past(ofs_sel)) &&
            (empty_ofs == ($past(ofs_sel) ? DEF_SER[OW-1:0] : DEF_PAR[OW-1:0])) &&
            (full_ofs  == ($past(ofs_sel) ? DEF_SER[OW-1:0] : DEF_PAR[OW-1:0])));

    p_partial_keeps_r2: assert property (@(posedge wr_clk) disable iff (!mst_rst_n)
        (w_started && !prt_rst_n) |=>
            $stable(empty_ofs) && $stable(full_ofs) && $stable(serial_mode));

    p_mismatch_ignored_r8: assert property (@(posedge wr_clk) disable iff (!mst_rst_n)
        (w_started && prt_rst_n && ofs_sel &&
         ((serial_mode && wr_en && !ser_en) || (!serial_mode && ser_en && !wr_en))) |=>
            $stable(empty_ofs) && $stable(full_ofs));

    p_no_mem_strobe_r7: assert property (@(posedge wr_clk)
        (ofs_sel || !mst_rst_n || !prt_rst_n) |-> (!mem_wr && !mem_rd));

    p_rd_vld_pulse_r5: assert property (@(posedge rd_clk)
        disable iff (!mst_rst_n || !prt_rst_n)
        (r_started && ofs_sel && rd_en) |=> ofs_rd_vld);

    p_rd_vld_idle_r5: assert property (@(posedge rd_clk)
        disable iff (!mst_rst_n || !prt_rst_n)
        (r_started && !(ofs_sel && rd_en)) |=> !ofs_rd_vld);

    p_rd_hold_r10: assert property (@(posedge rd_clk)
        disable iff (!mst_rst_n || !prt_rst_n)
        (r_started && $past(mst_rst_n && prt_rst_n) && !ofs_rd_vld) |-> $stable(rd_data));

endmodule

bind ofs_prog_unit ofs_prog_unit_chk #(
    .OW(OW), .DW(DW), .DEF_SER(DEF_SER), .DEF_PAR(DEF_PAR)
) chk_i (
    .wr_clk     (wr_clk),
    .rd_clk     (rd_clk),
    .mst_rst_n  (mst_rst_n),
    .prt_rst_n  (prt_rst_n),
    .ofs_sel    (ofs_sel),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .ser_en     (ser_en),
    .mem_wr     (mem_wr),
    .mem_rd     (mem_rd),
    .rd_data    (rd_data),
    .ofs_rd_vld (ofs_rd_vld),
    .empty_ofs  (empty_ofs),
    .full_ofs   (full_ofs),
    .serial_mode(serial_mode)
);

// File: tb/ofs_prog_unit_tb_top.sv
// Bench: directed corners plus seeded random traffic, compared after every
// edge against a reference model kept in bench variables.
module ofs_prog_unit_tb_top;

    localparam int DEPTH = 8192;
    localparam int DW    = 18;
    localparam int OW    = $clog2(DEPTH);
    localparam int CW    = 2 * OW;

    logic          clk = 1'b0;
    logic          mst_rst_n, prt_rst_n, ofs_sel, wr_en, rd_en, ser_en, ser_din;
    logic [DW-1:0] wr_data;
    logic          mem_wr, mem_rd, ofs_rd_vld, serial_mode;
    logic [DW-1:0] rd_data;
    logic [OW-1:0] empty_ofs, full_ofs;

    int checks = 0;
    int errors = 0;

    // Reference model state.
    logic [OW-1:0] m_e, m_f;
    logic          m_mode, m_wp, m_rp, m_vld;
    logic [DW-1:0] m_rd;

    always #2 clk = ~clk;

    ofs_prog_unit #(.DEPTH(DEPTH), .DW(DW)) dut_i (
        .wr_clk(clk), .rd_clk(clk),
        .mst_rst_n(mst_rst_n), .prt_rst_n(prt_rst_n),
        .ofs_sel(ofs_sel), .wr_en(wr_en), .rd_en(rd_en),
        .ser_en(ser_en), .ser_din(ser_din), .wr_data(wr_data),
        .mem_wr(mem_wr), .mem_rd(mem_rd), .rd_data(rd_data),
        .ofs_rd_vld(ofs_rd_vld), .empty_ofs(empty_ofs),
        .full_ofs(full_ofs), .serial_mode(serial_mode)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Model one edge for the inputs currently driven.
    function automatic void model_edge();
        logic [CW-1:0] ch;
        if (!mst_rst_n) begin
            m_mode = ofs_sel;
            m_e = ofs_sel ? OW'(1023) : OW'(127);
            m_f = m_e;
            m_wp = 0; m_rp = 0; m_rd = '0; m_vld = 0;
        end else if (!prt_rst_n) begin
            m_wp = 0; m_rp = 0; m_rd = '0; m_vld = 0;
        end else begin
            m_vld = ofs_sel && rd_en;
            if (m_vld) begin
                m_rd = DW'(m_rp ? m_f : m_e);
                m_rp = ~m_rp;
            end
            if (!m_mode && ofs_sel && wr_en) begin
                if (m_wp) m_f = wr_data[OW-1:0];
                else      m_e = wr_data[OW-1:0];
                m_wp = ~m_wp;
            end else if (m_mode && ofs_sel && ser_en) begin
                ch = {ser_din, m_f, m_e[OW-1:1]};
                {m_f, m_e} = ch;
            end
        end
    endfunction

    // Drive one cycle of inputs, check strobes, clock, check registers.
    task automatic step(input string tag, input logic mr, input logic pr,
                        input logic sel, input logic we, input logic re,
                        input logic se, input logic sd, input logic [DW-1:0] wd);
        @(negedge clk);
        mst_rst_n = mr; prt_rst_n = pr; ofs_sel = sel; wr_en = we;
        rd_en = re; ser_en = se; ser_din = sd; wr_data = wd;
        #1;
        chk("R7", "mem_wr", 32'(mem_wr), 32'(mr && pr && !sel && we));
        chk("R7", "mem_rd", 32'(mem_rd), 32'(mr && pr && !sel && re));
        model_edge();
        @(posedge clk);
        #1;
        chk(tag, "serial_mode", 32'(serial_mode), 32'(m_mode));
        chk(tag, "empty_ofs", 32'(empty_ofs), 32'(m_e));
        chk(tag, "full_ofs", 32'(full_ofs), 32'(m_f));
        chk(tag, "ofs_rd_vld", 32'(ofs_rd_vld), 32'(m_vld));
        chk(tag, "rd_data", 32'(rd_data), 32'(m_rd));
    endtask

    task automatic idle(input string tag);
        step(tag, 1, 1, 0, 0, 0, 0, 0, '0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [CW-1:0] pat;
        void'($urandom(32'd4711));
        mst_rst_n = 0; prt_rst_n = 1; ofs_sel = 0; wr_en = 0; rd_en = 0;
        ser_en = 0; ser_din = 0; wr_data = '0;

        // R1: serial strap gives 1023 defaults
        step("R1", 0, 1, 1, 0, 0, 0, 0, '0);
        chk("R1", "serial default", 32'(empty_ofs), 32'd1023);
        idle("R1");

        // R6: read-back in serial mode, empty then full
        step("R6", 1, 1, 1, 0, 1, 0, 0, '0);
        step("R6", 1, 1, 1, 0, 1, 0, 0, '0);

        // R4: full 26-bit shift of a known pattern lands as {full, empty}
        pat = CW'(26'h2A5_C3F1);
        for (int i = 0; i < CW; i++) step("R4", 1, 1, 1, 0, 0, 1, pat[i], '0);
        chk("R4", "chain", 32'({full_ofs, empty_ofs}), 32'(pat));

        // R8: parallel write while serial strapped is dropped
        step("R8", 1, 1, 1, 1, 0, 0, 0, DW'(18'h155));
        // R10: no read, rd_data held
        idle("R10");

        // R2: partial reset keeps offsets and mode, read pointer back to empty
        step("R2", 1, 0, 0, 0, 0, 0, 0, '0);
        step("R2", 1, 1, 1, 0, 1, 0, 0, '0);
        chk("R2", "read after partial", 32'(rd_data), 32'(pat[OW-1:0]));

        // R1: parallel strap gives 127 defaults
        step("R1", 0, 1, 0, 0, 0, 0, 0, '0);
        chk("R1", "parallel default", 32'(full_ofs), 32'd127);

        // R3/R9: alternating writes, then overwrite
        step("R3", 1, 1, 1, 1, 0, 0, 0, DW'(18'h0123));
        step("R3", 1, 1, 1, 1, 0, 0, 0, DW'(18'h1F00));
        step("R9", 1, 1, 1, 1, 0, 0, 0, DW'(18'h0007));
        // R8: serial shift in parallel mode is dropped, pointer unmoved
        step("R8", 1, 1, 1, 0, 0, 1, 1, '0);
        step("R8", 1, 1, 1, 1, 0, 0, 0, DW'(18'h0ABC));
        chk("R8", "full after skip", 32'(full_ofs), 32'h0ABC);

        // R5: reads alternate, valid pulses once
        step("R5", 1, 1, 1, 0, 1, 0, 0, '0);
        step("R5", 1, 1, 1, 0, 1, 0, 0, '0);
        idle("R5");
        // R7: memory traffic with offsets deselected
        step("R7", 1, 1, 0, 1, 1, 0, 0, DW'(18'h3FFFF));

        // R9: seeded random mix across both methods
        for (int n = 0; n < 3000; n++) begin
            int k = $urandom_range(0, 99);
            step("R9", (k != 0), (k != 1),
                 ($urandom_range(0, 3) != 0), 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), DW'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule